// File: doc/BRIEF.md
# DMA Bus Hold Handshake Controller

This block decides when a DMA engine may begin a transfer that uses external data memory. It does this through an active-low hold request / hold acknowledge handshake on two shared pins. Software enables one of two modes, or neither. In requester mode the block drives a hold request and holds back the DMA start until an acknowledge comes back. In arbiter mode another bus master drives the request. The block grants an acknowledge once any external DMA it is already running has finished. While that acknowledge is held, the block starts no new external DMA.

The DMA engine raises `dma_start` with the qualifier `dma_ext` (1 = the transfer touches external memory). It holds both until it sees a `dma_go` pulse. A transfer with both ends internal is released at once, in every mode and state where the controller is not busy with an external transfer. The CPU is never stalled: only the DMA start is held off. CPU fetches and CPU data moves do not pass through this block.

Each pin is split at the pad into an input, an output value and an output enable. Incoming pin levels pass through a two-stage synchronizer before the control logic uses them.

The control machine has five states:
- `HH_IDLE`: nothing pending.
- `HH_REQ`: requester mode, hold request driven, waiting for the acknowledge.
- `HH_GO`: the one cycle in which an external DMA is released.
- `HH_BUSY`: an external DMA is running until `dma_done`.
- `HH_GRANT`: arbiter mode, acknowledge driven to the other master.

Its transitions are:
- IDLE→GRANT: arbiter mode and the synchronized request is active. This takes priority over a pending external start.
- IDLE→REQ: an external start in requester mode.
- IDLE→GO: an external start in arbiter mode or with no mode.
- REQ→GO: the synchronized acknowledge is low.
- REQ→IDLE: requester mode is withdrawn.
- GO→BUSY: normal case.
- GO→IDLE: `dma_done` arrives in the same cycle.
- BUSY→IDLE: `dma_done`.
- GRANT→IDLE: the synchronized request goes inactive, or arbiter mode is withdrawn.

Top module: `dma_hold_ctrl`

## Requirements
- R1: After reset `dma_go` is 0, and every driven pin output is at its inactive level, logic 1.
- R2: Pin direction follows the mode bits. Requester only gives `hold_oe`=1 and `ack_oe`=0. Arbiter only gives `hold_oe`=0 and `ack_oe`=1. With both bits set, requester mode takes precedence.
- R3: In requester mode an external start drives `hold_o`=0 from the next cycle. `dma_go` stays 0 until `ack_i` is low. If `ack_i` falls just before edge k, `dma_go` is 1 in the cycle after edge k+2.
- R4: In requester mode, once an external DMA is released, `hold_o` stays 0 whatever `ack_i` does. It returns to 1 in the cycle after the one in which `dma_done` is 1.
- R5: A start with `dma_ext`=0 gives `dma_go`=1 in the same cycle without asserting a hold request. This also applies while an acknowledge is granted in arbiter mode.
- R6: In arbiter mode with no external DMA running, `ack_o` goes to 0 in the cycle after edge k+2 when `hold_i` falls just before edge k.
- R7: In arbiter mode a request that arrives during an external DMA is not acknowledged until that DMA ends. `ack_o` goes to 0 two cycles after the cycle in which `dma_done` is 1.
- R8: While `ack_o`=0, no external DMA is released. When `hold_i` rises just before edge k, `ack_o` returns to 1 after edge k+2, and a pending external start gets `dma_go` one cycle later.
- R9: With neither mode enabled, both output enables are 0 and an external start is released in the next cycle.
- R10: `dma_go` for an external DMA is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mode_en | input | 1 | Requester mode enable |
| arb_mode_en | input | 1 | Arbiter mode enable |
| dma_start | input | 1 | DMA engine wants to start, held until `dma_go` |
| dma_ext | input | 1 | Pending DMA touches external data memory |
| dma_done | input | 1 | One-cycle pulse at the end of an external DMA |
| dma_go | output | 1 | DMA may start |
| hold_i | input | 1 | Level seen on the hold pin |
| hold_o | output | 1 | Value driven on the hold pin (active low) |
| hold_oe | output | 1 | Hold pin output enable |
| ack_i | input | 1 | Level seen on the acknowledge pin |
| ack_o | output | 1 | Value driven on the acknowledge pin (active low) |
| ack_oe | output | 1 | Acknowledge pin output enable |

## Verification
The assertions take some things for granted about the inputs:
- The mode bits change only while the controller is idle.
- `dma_ext` stays steady from the start request until the cycle after the go pulse.
- In requester mode, the acknowledge stays low at least until the go pulse is seen.
- The engine drops `dma_start` in the half cycle in which it sees `dma_go`.

The directed tasks change modes only after all activity has settled. They hold the acknowledge low until the go pulse appears, and they release start at the same falling edge at which the go is observed. The pin inputs are driven at falling edges with several idle cycles between scenarios, so the synchronizers always reach a settled level.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;

    typedef enum logic [2:0] {
        HH_IDLE,
        HH_REQ,
        HH_GO,
        HH_BUSY,
        HH_GRANT
    } hh_state_e;

    localparam int unsigned HH_PIN_COUNT = 2;
    localparam int unsigned HH_PIN_HOLD  = 0;
    localparam int unsigned HH_PIN_ACK   = 1;

endpackage

// File: rtl/dma_hold_sync.sv
module dma_hold_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= {STAGES{RESET_VAL}};
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d};
        end
    end

    assign q = shift_q[LAST];
endmodule

// File: rtl/dma_hold_pins.sv
module dma_hold_pins (
    input  logic req_en,
    input  logic arb_en,
    input  logic hold_assert,
    input  logic ack_assert,
    input  logic hold_sync,
    input  logic ack_sync,
    output logic req_mode,
    output logic arb_mode,
    output logic hold_o,
    output logic hold_oe,
    output logic ack_o,
    output logic ack_oe,
    output logic hold_act,
    output logic ack_act
);
    // Requester takes precedence when software sets both bits.
    always_comb begin
        req_mode = req_en;
        arb_mode = arb_en & ~req_en;
        hold_oe  = req_mode;
        ack_oe   = arb_mode;
        hold_o   = ~hold_assert;
        ack_o    = ~ack_assert;
        hold_act = arb_mode & ~hold_sync;
        ack_act  = req_mode & ~ack_sync;
    end
endmodule

// File: rtl/dma_hold_fsm.sv
module dma_hold_fsm
    import dma_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_mode,
    input  logic arb_mode,
    input  logic dma_start,
    input  logic dma_ext,
    input  logic dma_done,
    input  logic hold_act,
    input  logic ack_act,
    output logic hold_assert,
    output logic ack_assert,
    output logic dma_go
);
    hh_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HH_IDLE: begin
                if (arb_mode && hold_act) begin
                    state_d = HH_GRANT;
                end else if (dma_start && dma_ext) begin
                    state_d = req_mode ? HH_REQ : HH_GO;
                end
            end
            HH_REQ: begin
                if (!req_mode) begin
                    state_d = HH_IDLE;
                end else if (ack_act) begin
                    state_d = HH_GO;
                end
            end
            HH_GO: begin
                state_d = dma_done ? HH_IDLE : HH_BUSY;
            end
            HH_BUSY: begin
                if (dma_done) begin
                    state_d = HH_IDLE;
                end
            end
            HH_GRANT: begin
                if (!arb_mode || !hold_act) begin
                    state_d = HH_IDLE;
                end
            end
            default: state_d = HH_IDLE;
        endcase
    end

    logic internal_go;

    always_comb begin
        internal_go = dma_start && !dma_ext &&
                      ((state_q == HH_IDLE) || (state_q == HH_GRANT));
        hold_assert = req_mode &&
                      ((state_q == HH_REQ) || (state_q == HH_GO) || (state_q == HH_BUSY));
        ack_assert  = (state_q == HH_GRANT);
        dma_go      = (state_q == HH_GO) || internal_go;
    end
endmodule

// File: rtl/dma_hold_ctrl.sv
module dma_hold_ctrl
    import dma_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_mode_en,
    input  logic arb_mode_en,
    input  logic dma_start,
    input  logic dma_ext,
    input  logic dma_done,
    output logic dma_go,
    input  logic hold_i,
    output logic hold_o,
    output logic hold_oe,
    input  logic ack_i,
    output logic ack_o,
    output logic ack_oe
);
    logic [HH_PIN_COUNT-1:0] pin_raw;
    logic [HH_PIN_COUNT-1:0] pin_sync;

    assign pin_raw[HH_PIN_HOLD] = hold_i;
    assign pin_raw[HH_PIN_ACK]  = ack_i;

    for (genvar g = 0; g < HH_PIN_COUNT; g++) begin : g_sync
        dma_hold_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
        ) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_raw[g]),
            .q    (pin_sync[g])
        );
    end

    logic req_mode, arb_mode, hold_act, ack_act, hold_assert, ack_assert;

    dma_hold_pins pins_i (
        .req_en     (req_mode_en),
        .arb_en     (arb_mode_en),
        .hold_assert(hold_assert),
        .ack_assert (ack_assert),
        .hold_sync  (pin_sync[HH_PIN_HOLD]),
        .ack_sync   (pin_sync[HH_PIN_ACK]),
        .req_mode   (req_mode),
        .arb_mode   (arb_mode),
        .hold_o     (hold_o),
        .hold_oe    (hold_oe),
        .ack_o      (ack_o),
        .ack_oe     (ack_oe),
        .hold_act   (hold_act),
        .ack_act    (ack_act)
    );

    dma_hold_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_mode   (req_mode),
        .arb_mode   (arb_mode),
        .dma_start  (dma_start),
        .dma_ext    (dma_ext),
        .dma_done   (dma_done),
        .hold_act   (hold_act),
        .ack_act    (ack_act),
        .hold_assert(hold_assert),
        .ack_assert (ack_assert),
        .dma_go     (dma_go)
    );
endmodule

// File: rtl/dma_hold_ctrl_chk.sv
module dma_hold_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_mode_en,
    input logic arb_mode_en,
    input logic dma_ext,
    input logic dma_done,
    input logic dma_go,
    input logic hold_o,
    input logic hold_oe,
    input logic ack_i,
    input logic ack_o,
    input logic ack_oe
);
    // R2: the two pins never drive at the same time
    a_r2_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_oe && ack_oe));

    // R9: no mode, no driven pin
    a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_mode_en && !arb_mode_en) |-> (!hold_oe && !ack_oe));

    // R3: external release in requester mode follows a low acknowledge
    a_r3_ack_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode_en && dma_go && dma_ext) |-> !$past(ack_i));

    // R4: the hold request is kept until the transfer ends
    a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode_en && !hold_o && !dma_done) |=> (!req_mode_en || !hold_o));

    // R5: an internal release raises no hold request
    a_r5_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode_en && dma_go && !dma_ext && hold_o) |=> hold_o);

    // R8: no external release while the acknowledge is granted
    a_r8_no_go_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && !ack_o) |-> !(dma_go && dma_ext));

    // R10: external release is a single cycle
    a_r10_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_go && dma_ext) |=> !dma_go);
endmodule

bind dma_hold_ctrl dma_hold_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_mode_en(req_mode_en),
    .arb_mode_en(arb_mode_en),
    .dma_ext    (dma_ext),
    .dma_done   (dma_done),
    .dma_go     (dma_go),
    .hold_o     (hold_o),
    .hold_oe    (hold_oe),
    .ack_i      (ack_i),
    .ack_o      (ack_o),
    .ack_oe     (ack_oe)
);

// File: tb/dma_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_hold_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_mode_en = 1'b0, arb_mode_en = 1'b0;
    logic dma_start = 1'b0, dma_ext = 1'b0, dma_done = 1'b0;
    logic hold_i = 1'b1, ack_i = 1'b1;
    logic dma_go, hold_o, hold_oe, ack_o, ack_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_mode_en(req_mode_en), .arb_mode_en(arb_mode_en),
        .dma_start(dma_start), .dma_ext(dma_ext), .dma_done(dma_done),
        .dma_go(dma_go),
        .hold_i(hold_i), .hold_o(hold_o), .hold_oe(hold_oe),
        .ack_i(ack_i), .ack_o(ack_o), .ack_oe(ack_oe)
    );

    task automatic chk(input string tag, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", tag, actual, expected, $time);
        end
    endtask

    task automatic neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        dma_done = 1'b1;
        neg(1);
        dma_done = 1'b0;
    endtask

    task automatic t_reset();
        neg(3);
        rst_n = 1'b1;
        neg(1);
        chk("R1 go after reset", dma_go, 1'b0);
        chk("R1 hold_oe after reset", hold_oe, 1'b0);
        chk("R1 ack_oe after reset", ack_oe, 1'b0);
        req_mode_en = 1'b1;
        #1;
        chk("R1 hold_o idle", hold_o, 1'b1);
        arb_mode_en = 1'b1; req_mode_en = 1'b0;
        #1;
        chk("R1 ack_o idle", ack_o, 1'b1);
        arb_mode_en = 1'b0;
        neg(2);
    endtask

    task automatic t_modes();
        req_mode_en = 1'b1; arb_mode_en = 1'b0; #1;
        chk("R2 req hold_oe", hold_oe, 1'b1);
        chk("R2 req ack_oe", ack_oe, 1'b0);
        req_mode_en = 1'b0; arb_mode_en = 1'b1; #1;
        chk("R2 arb hold_oe", hold_oe, 1'b0);
        chk("R2 arb ack_oe", ack_oe, 1'b1);
        req_mode_en = 1'b1; arb_mode_en = 1'b1; #1;
        chk("R2 both hold_oe", hold_oe, 1'b1);
        chk("R2 both ack_oe", ack_oe, 1'b0);
        req_mode_en = 1'b0; arb_mode_en = 1'b0; #1;
        chk("R9 none hold_oe", hold_oe, 1'b0);
        chk("R9 none ack_oe", ack_oe, 1'b0);
        neg(2);
    endtask

    task automatic t_neither();
        dma_start = 1'b1; dma_ext = 1'b1;
        #1;
        chk("R9 no same-cycle go", dma_go, 1'b0);
        neg(1);
        chk("R9 go next cycle", dma_go, 1'b1);
        dma_start = 1'b0;
        neg(1);
        chk("R10 go single cycle", dma_go, 1'b0);
        done_pulse();
        neg(3);
    endtask

    task automatic t_requester();
        req_mode_en = 1'b1;
        neg(1);
        dma_start = 1'b1; dma_ext = 1'b1;
        neg(1);
        chk("R3 hold asserted", hold_o, 1'b0);
        chk("R3 no go before ack", dma_go, 1'b0);
        ack_i = 1'b0;
        neg(2);
        chk("R3 go not yet", dma_go, 1'b0);
        neg(1);
        chk("R3 go after synced ack", dma_go, 1'b1);
        dma_start = 1'b0; ack_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            neg(1);
            chk("R4 hold kept with ack high", hold_o, 1'b0);
            chk("R10 no repeated go", dma_go, 1'b0);
        end
        dma_done = 1'b1;
        #1;
        chk("R4 hold held in done cycle", hold_o, 1'b0);
        neg(1);
        dma_done = 1'b0;
        chk("R4 hold released after done", hold_o, 1'b1);
        neg(3);
    endtask

    task automatic t_internal();
        dma_start = 1'b1; dma_ext = 1'b0;
        #1;
        chk("R5 internal go same cycle", dma_go, 1'b1);
        chk("R5 no hold for internal", hold_o, 1'b1);
        neg(1);
        dma_start = 1'b0;
        #1;
        chk("R5 hold still idle", hold_o, 1'b1);
        neg(1);
        chk("R5 hold idle later", hold_o, 1'b1);
        req_mode_en = 1'b0;
        neg(2);
    endtask

    task automatic t_arb_idle();
        arb_mode_en = 1'b1;
        neg(1);
        hold_i = 1'b0;
        neg(2);
        chk("R6 ack not yet", ack_o, 1'b1);
        neg(1);
        chk("R6 ack granted", ack_o, 1'b0);
        hold_i = 1'b1;
        neg(2);
        chk("R8 ack still held", ack_o, 1'b0);
        neg(1);
        chk("R8 ack released", ack_o, 1'b1);
        neg(3);
    endtask

    task automatic t_arb_busy();
        dma_start = 1'b1; dma_ext = 1'b1;
        neg(1);
        chk("R7 ext go without request", dma_go, 1'b1);
        dma_start = 1'b0; hold_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            neg(1);
            chk("R7 no ack during DMA", ack_o, 1'b1);
        end
        done_pulse();
        chk("R7 ack not in cycle after done", ack_o, 1'b1);
        neg(1);
        chk("R7 ack after done", ack_o, 1'b0);
        hold_i = 1'b1;
        neg(4);
        chk("R8 ack released after busy", ack_o, 1'b1);
        neg(2);
    endtask

    task automatic t_arb_pending();
        hold_i = 1'b0;
        neg(3);
        chk("R6 grant for pending test", ack_o, 1'b0);
        dma_start = 1'b1; dma_ext = 1'b0;
        #1;
        chk("R5 internal go during grant", dma_go, 1'b1);
        neg(1);
        dma_start = 1'b0;
        neg(1);
        dma_start = 1'b1; dma_ext = 1'b1;
        for (int i = 0; i < 3; i++) begin
            neg(1);
            chk("R8 ext held during grant", dma_go, 1'b0);
        end
        hold_i = 1'b1;
        neg(2);
        chk("R8 ack held two cycles", ack_o, 1'b0);
        neg(1);
        chk("R8 ack released", ack_o, 1'b1);
        chk("R8 go not with release", dma_go, 1'b0);
        neg(1);
        chk("R8 pending go", dma_go, 1'b1);
        dma_start = 1'b0;
        neg(1);
        done_pulse();
        arb_mode_en = 1'b0;
        neg(2);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_neither();
        t_requester();
        t_internal();
        t_arb_idle();
        t_arb_busy();
        t_arb_pending();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule